// File: doc/BRIEF.md
# Audio Zero-Run Detect Flag

This block watches a stereo PCM sample stream, one left/right pair per valid strobe, and raises a zero flag once a channel has carried a long unbroken run of all-zero samples. Each channel has its own saturating run counter. A channel selector combines the two channel results into the flag. It can require both channels, use only the left channel, use only the right channel, or turn the flag off. A force-high control overrides the selector.

The flag is meant to drive an external mute circuit. When the infinite-zero-detect enable is set, the same condition also raises an analogue-mute request. Detection runs only while the stream is marked as PCM.

The control inputs come from a register file outside the block. That register file resets the channel select to 00 (both channels) and clears the force-high and infinite-zero-detect bits.

Top module: `audio_zero_flag`

## Requirements
- R1: With `chan_sel` = 00 and PCM mode, `zero_flag` stays 0 after exactly RUN_LIMIT (default 1024) consecutive valid all-zero samples on both channels. It becomes 1 after RUN_LIMIT+1 such samples on both channels. A sample counts as zero only when every one of its SAMPLE_W bits is 0.
- R2: While `rst` is high and on the first cycle after it, `zero_flag` and `mute_req` are 0. Both outputs are registered and change on the first rising edge after the sample or control value that causes the change.
- R3: A valid nonzero sample on a channel restarts that channel's run. Its detect, and a flag that depends on it, drops on the next rising edge.
- R4: `chan_sel` selects the flag source: 00 = left AND right, 01 = left only, 10 = right only, 11 = flag held at 0.
- R5: When `force_hi` is 1, `zero_flag` is 1 on the next edge, whatever the channel select and the run state. When `force_hi` is 0, R4 applies.
- R6: While `pcm_mode` is 0, both channel detects are held at 0 and both runs restart. A new run begins only when PCM mode returns.
- R7: When `izd_en` is 1, `mute_req` equals `zero_flag` on every cycle, including while the flag is forced high. When `izd_en` is 0, `mute_req` is 0.
- R8: Cycles with `smp_vld` = 0 neither advance nor restart a run, whatever the sample data.
- R9: Runs saturate, so the flag stays 1 through silence of any length with no wraparound. This is checked over more than 4000 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample pair valid strobe |
| smp_left | input | SAMPLE_W | Left channel sample, two's complement |
| smp_right | input | SAMPLE_W | Right channel sample, two's complement |
| pcm_mode | input | 1 | 1 = stream is PCM, detection enabled |
| chan_sel | input | 2 | Flag source select (R4 encoding) |
| force_hi | input | 1 | Force flag to 1 |
| izd_en | input | 1 | Link the flag to the mute request |
| zero_flag | output | 1 | Registered zero flag |
| mute_req | output | 1 | Registered analogue-mute request |

## Verification
Two events can fall on the same edge. In the first, a channel's run completes just as force-high is released. The bench drives the final qualifying zero pair on the same cycle that `force_hi` drops, and expects the flag to stay at 1 with no gap. In the second, a nonzero sample clears a run on the same cycle that `force_hi` rises. Here the override must win and the flag must read 1. In a separate case the completing run on one channel meets a nonzero sample on the other, and the left-only, right-only and AND selections must each resolve that cycle correctly. A cycle-accurate model in the bench judges every cycle of these sweeps.

// File: rtl/zrd_pkg.sv
package zrd_pkg;

  typedef enum logic [1:0] {
    SEL_BOTH  = 2'b00,
    SEL_LEFT  = 2'b01,
    SEL_RIGHT = 2'b10,
    SEL_OFF   = 2'b11
  } zsel_e;

endpackage

// File: rtl/zrd_run_counter.sv
module zrd_run_counter #(
  parameter int SAMPLE_W  = 24,
  parameter int RUN_LIMIT = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld,
  input  logic                pcm,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                hit_nxt
);

  localparam int CNT_W = $clog2(RUN_LIMIT + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(RUN_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             is_zero;

  assign is_zero = (sample == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!pcm) begin
      cnt_d = '0;
    end else if (vld) begin
      if (!is_zero)          cnt_d = '0;
      else if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  assign hit_nxt = (cnt_d == SAT);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/zrd_chan_combine.sv
module zrd_chan_combine
  import zrd_pkg::*;
(
  input  logic       hit_l,
  input  logic       hit_r,
  input  logic [1:0] sel,
  input  logic       force_hi,
  output logic       flag
);

  always_comb begin
    unique case (zsel_e'(sel))
      SEL_BOTH:  flag = hit_l & hit_r;
      SEL_LEFT:  flag = hit_l;
      SEL_RIGHT: flag = hit_r;
      default:   flag = 1'b0;
    endcase
    if (force_hi) flag = 1'b1;
  end

endmodule

// File: rtl/audio_zero_flag.sv
module audio_zero_flag #(
  parameter int SAMPLE_W  = 24,
  parameter int RUN_LIMIT = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                pcm_mode,
  input  logic [1:0]          chan_sel,
  input  logic                force_hi,
  input  logic                izd_en,
  output logic                zero_flag,
  output logic                mute_req
);

  localparam int NCH = 2;

  logic [SAMPLE_W-1:0] ch_smp [NCH];
  logic [NCH-1:0]      ch_hit;
  logic                flag_d;

  assign ch_smp[0] = smp_left;
  assign ch_smp[1] = smp_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zrd_run_counter #(
      .SAMPLE_W  (SAMPLE_W),
      .RUN_LIMIT (RUN_LIMIT)
    ) u_run (
      .clk     (clk),
      .rst     (rst),
      .vld     (smp_vld),
      .pcm     (pcm_mode),
      .sample  (ch_smp[c]),
      .hit_nxt (ch_hit[c])
    );
  end

  zrd_chan_combine u_comb (
    .hit_l    (ch_hit[0]),
    .hit_r    (ch_hit[1]),
    .sel      (chan_sel),
    .force_hi (force_hi),
    .flag     (flag_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_flag <= 1'b0;
      mute_req  <= 1'b0;
    end else begin
      zero_flag <= flag_d;
      mute_req  <= flag_d & izd_en;
    end
  end

endmodule

// File: rtl/zrd_checker.sv
module zrd_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_vld,
  input logic [SAMPLE_W-1:0] smp_left,
  input logic                pcm_mode,
  input logic [1:0]          chan_sel,
  input logic                force_hi,
  input logic                izd_en,
  input logic                zero_flag,
  input logic                mute_req
);

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    force_hi |=> zero_flag); // R5

  AST_SEL_OFF: assert property (@(posedge clk) disable iff (rst)
    (chan_sel == 2'b11 && !force_hi) |=> !zero_flag); // R4

  AST_NONPCM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pcm_mode && !force_hi) |=> !zero_flag); // R6

  AST_LEFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && smp_left != '0 && chan_sel == 2'b01 && !force_hi) |=> !zero_flag); // R3

  AST_MUTE_OFF: assert property (@(posedge clk) disable iff (rst)
    !izd_en |=> !mute_req); // R7

  AST_MUTE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    izd_en |=> (mute_req == zero_flag)); // R7

endmodule

bind audio_zero_flag zrd_checker #(.SAMPLE_W(SAMPLE_W)) u_zrd_checker (
  .clk       (clk),
  .rst       (rst),
  .smp_vld   (smp_vld),
  .smp_left  (smp_left),
  .pcm_mode  (pcm_mode),
  .chan_sel  (chan_sel),
  .force_hi  (force_hi),
  .izd_en    (izd_en),
  .zero_flag (zero_flag),
  .mute_req  (mute_req)
);

// File: tb/audio_zero_flag_tb.sv
module audio_zero_flag_tb;

  localparam int SW  = 24;
  localparam int LIM = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_vld = 1'b0;
  logic [SW-1:0] smp_left = '0;
  logic [SW-1:0] smp_right = '0;
  logic          pcm_mode = 1'b1;
  logic [1:0]    chan_sel = 2'b00;
  logic          force_hi = 1'b0;
  logic          izd_en = 1'b0;
  logic          zero_flag;
  logic          mute_req;

  int checks = 0;
  int errors = 0;
  int run_l = 0;
  int run_r = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  audio_zero_flag #(.SAMPLE_W(SW), .RUN_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_left(smp_left),
    .smp_right(smp_right), .pcm_mode(pcm_mode), .chan_sel(chan_sel),
    .force_hi(force_hi), .izd_en(izd_en), .zero_flag(zero_flag),
    .mute_req(mute_req)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int next_run(input int cur, input logic v, input logic [SW-1:0] s);
    if (!pcm_mode) return 0;
    if (!v) return cur;
    if (s != 0) return 0;
    return (cur > LIM) ? LIM + 1 : cur + 1;
  endfunction

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic v, input logic [SW-1:0] l, input logic [SW-1:0] r,
                      input string tag);
    logic dl, dr, ef;
    smp_vld = v; smp_left = l; smp_right = r;
    @(posedge clk);
    run_l = next_run(run_l, v, l);
    run_r = next_run(run_r, v, r);
    dl = (run_l > LIM);
    dr = (run_r > LIM);
    case (chan_sel)
      2'b00:   ef = dl & dr;
      2'b01:   ef = dl;
      2'b10:   ef = dr;
      default: ef = 1'b0;
    endcase
    if (force_hi) ef = 1'b1;
    @(negedge clk);
    cyc++;
    check(tag, zero_flag, ef);
    check("R7", mute_req, ef & izd_en);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", zero_flag, 1'b0);
    check("R2", mute_req, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", zero_flag, 1'b0);
    check("R2", mute_req, 1'b0);

    // R1: threshold, exactly LIM stays low
    izd_en = 1'b1;
    for (int i = 0; i < LIM; i++) step(1'b1, '0, '0, "R1");
    check("R1", zero_flag, 1'b0);
    step(1'b1, '0, '0, "R1");
    check("R1", zero_flag, 1'b1);
    check("R7", mute_req, 1'b1);

    // R9: long silence, no wrap
    for (int i = 0; i < 3000; i++) step(1'b1, '0, '0, "R9");
    check("R9", zero_flag, 1'b1);

    // R3: nonzero on one channel clears at once
    step(1'b1, SW'(5), '0, "R3");
    check("R3", zero_flag, 1'b0);
    step(1'b1, '0, {1'b1, {(SW-1){1'b0}}}, "R3");

    // R8: invalid cycles hold the run
    for (int i = 0; i < 1000; i++) step(1'b1, '0, '0, "R8");
    for (int i = 0; i < 40; i++) step(1'b0, SW'(i + 1), SW'(7), "R8");
    for (int i = 0; i < 25; i++) step(1'b1, '0, '0, "R8");
    check("R8", zero_flag, 1'b1);

    // R4: select sweep with one-sided and two-sided runs
    for (int s = 0; s < 4; s++) begin
      chan_sel = 2'(s);
      izd_en = s[0];
      for (int p = 0; p < 3; p++) begin
        step(1'b1, SW'(1), SW'(1), "R4");
        for (int i = 0; i < LIM + 60; i++)
          step(1'b1, (p == 1) ? SW'(i + 1) : '0, (p == 0) ? SW'(3) : '0, "R4");
      end
    end

    // R6: non-PCM holds detect low and restarts runs
    chan_sel = 2'b00; izd_en = 1'b1;
    pcm_mode = 1'b0;
    for (int i = 0; i < LIM + 20; i++) step(1'b1, '0, '0, "R6");
    check("R6", zero_flag, 1'b0);
    pcm_mode = 1'b1;
    for (int i = 0; i < LIM; i++) step(1'b1, '0, '0, "R6");
    check("R6", zero_flag, 1'b0);
    step(1'b1, '0, '0, "R6");
    check("R6", zero_flag, 1'b1);

    // R5: force overrides select-off and nonzero data
    chan_sel = 2'b11; force_hi = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b1, SW'(9), SW'(9), "R5");
    check("R5", zero_flag, 1'b1);
    check("R7", mute_req, 1'b1);
    force_hi = 1'b0;
    step(1'b1, SW'(9), SW'(9), "R5");
    check("R5", zero_flag, 1'b0);

    // coincidence: force released on the completing edge
    chan_sel = 2'b00; force_hi = 1'b1;
    for (int i = 0; i < LIM; i++) step(1'b1, '0, '0, "R5");
    force_hi = 1'b0;
    step(1'b1, '0, '0, "R5");
    check("R5", zero_flag, 1'b1);
    // coincidence: nonzero clears while force rises
    force_hi = 1'b1;
    step(1'b1, SW'(2), '0, "R5");
    check("R5", zero_flag, 1'b1);
    force_hi = 1'b0; izd_en = 1'b0;
    step(1'b1, '0, '0, "R3");
    check("R3", zero_flag, 1'b0);
    check("R7", mute_req, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule